// File: doc/BRIEF.md
# Modem Status and Interrupt Controller

This block keeps the host-visible status byte of a symbol-based modem data pump and decides when the host must be interrupted. The modem core reports four kinds of event: the data block buffer becoming free, the input buffer running empty, an input overflow, and a special symbol having been sent or received. The host supplies the mode bits and command (task) writes, and it reads the status byte through a read strobe.

The interrupt flag is raised only on 0-to-1 transitions of selected status bits. Transitions that a reset task or a change of the transmit/receive or power-save mode could produce are suppressed for a short window, so that reconfiguring the modem does not cause spurious interrupts. The interrupt pin is modelled as a "pull low" enable for an open-drain active-low line.

Top module: `modem_stat_irq`

## Requirements
- R1: After a synchronous reset the status byte is 0x40: the buffer-free bit is 1 and every other bit is 0. The interrupt pin is released.
- R2: The status byte layout is: bit 7 interrupt flag, bit 6 buffer free, bit 5 input buffer empty, bit 4 overflow, bit 3 symbol ready, bit 2 always 0, bits 1:0 last received symbol. The empty and overflow bits follow the core inputs one clock later.
- R3: A 0-to-1 change of the overflow bit sets the interrupt flag, even inside the mask window.
- R4: A 0-to-1 change of the buffer-free bit sets the interrupt flag unless it falls in the mask window.
- R5: A 0-to-1 change of the input-buffer-empty bit sets the interrupt flag unless it falls in the mask window.
- R6: The mask window covers the clock in which a RESET task (code 1) is written or the transmit/receive or power-save mode input changes, and also the clock after it. A RESET task or such a mode change sets the buffer-free bit.
- R7: A symbol strobe sets the symbol-ready bit. In receive mode (mode select 0) it also loads the 2-bit symbol value into bits 1:0. When the symbol interrupt enable is 1, it also sets the interrupt flag.
- R8: A status read clears the interrupt flag and the symbol-ready bit one clock later. If a setting event occurs in the same clock as the read, that bit stays set.
- R9: The interrupt pin pulls low exactly while the pin enable is 1 and the interrupt flag is 1. It is released once a read has cleared the flag.
- R10: Writing a task code other than NULL (0) or RESET (1) clears the buffer-free bit. This clear takes priority over a buffer-free event from the core in the same clock.
- R11: The next-symbol output equals mode bits 1:0 in transmit mode (mode select 1) and is 0 in receive mode. In receive mode those mode bits do not affect the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_tx | input | 1 | 1 = transmit, 0 = receive |
| mode_psave | input | 1 | Power-save mode bit |
| mode_sym_ien | input | 1 | Symbol interrupt enable |
| mode_pin_en | input | 1 | Interrupt pin enable |
| mode_sym | input | 2 | Next special symbol to send |
| cmd_wr | input | 1 | Command write strobe |
| cmd_task | input | 4 | Task code of the command write |
| core_bfree_set | input | 1 | Core reports buffer free |
| core_in_empty | input | 1 | Core input-buffer-empty level |
| core_ovf | input | 1 | Core overflow level |
| core_sym_stb | input | 1 | Special symbol sent or received |
| core_sym_val | input | 2 | Received symbol value |
| stat_rd | input | 1 | Host status read strobe |
| status_o | output | 8 | Status byte |
| irq_o | output | 1 | Interrupt flag |
| irq_pull_low_o | output | 1 | 1 = drive the active-low interrupt line low |
| tx_sym_o | output | 2 | Symbol passed to the modulator |

## Verification
Every status bit and the interrupt flag change on the first clock edge after the stimulus is applied. The pin output follows the flag in the same cycle, and the next-symbol output follows the mode inputs with no delay. The mask window extends one extra edge after a reset task or a mode change. The bench drives each input set at a falling edge, advances a cycle-accurate expected model, and compares at the next falling edge, which is exactly one rising edge later. Directed sequences put events inside and just outside the mask window, and they place reads and set events in the same clock.

// File: rtl/msi_pkg.sv
`timescale 1ns/1ps
package msi_pkg;
    localparam int TASK_W = 4;
    localparam int SYM_W  = 2;

    typedef logic [TASK_W-1:0] task_t;
    typedef logic [SYM_W-1:0]  sym_t;

    localparam task_t TASK_NULL  = task_t'(0);
    localparam task_t TASK_RESET = task_t'(1);

    typedef struct packed {
        logic irq;
        logic bfree;
        logic in_empty;
        logic ovf;
        logic srdy;
        logic spare;
        sym_t sval;
    } status_t;

    localparam int STAT_W = $bits(status_t);

    function automatic logic occupies_buffer(task_t t);
        return (t != TASK_NULL) && (t != TASK_RESET);
    endfunction

    function automatic logic went_high(logic nxt, logic cur);
        return nxt & ~cur;
    endfunction
endpackage

// File: rtl/msi_mask_gen.sv
`timescale 1ns/1ps
module msi_mask_gen
    import msi_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  mode_tx,
    input  logic  mode_psave,
    input  logic  cmd_wr,
    input  task_t cmd_task,
    output logic  reinit_o,
    output logic  mask_o
);
    logic tx_prev_q, ps_prev_q, mask_q;

    assign reinit_o = (cmd_wr && cmd_task == TASK_RESET)
                    || (mode_tx != tx_prev_q)
                    || (mode_psave != ps_prev_q);
    assign mask_o = reinit_o | mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_prev_q <= 1'b0;
            ps_prev_q <= 1'b0;
            mask_q    <= 1'b0;
        end else begin
            tx_prev_q <= mode_tx;
            ps_prev_q <= mode_psave;
            mask_q    <= reinit_o;
        end
    end

    assert_mask_tail_R6: assert property (@(posedge clk) disable iff (rst)
        reinit_o |=> mask_o);
endmodule

// File: rtl/msi_status_regs.sv
`timescale 1ns/1ps
module msi_status_regs
    import msi_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  reinit,
    input  logic  cmd_wr,
    input  task_t cmd_task,
    input  logic  core_bfree_set,
    input  logic  core_in_empty,
    input  logic  core_ovf,
    input  logic  core_sym_stb,
    input  sym_t  core_sym_val,
    input  logic  mode_tx,
    input  logic  stat_rd,
    output logic  bfree_o,
    output logic  in_empty_o,
    output logic  ovf_o,
    output logic  srdy_o,
    output sym_t  sval_o,
    output logic  bfree_rise_o,
    output logic  empty_rise_o,
    output logic  ovf_rise_o
);
    logic bfree_q, empty_q, ovf_q, srdy_q;
    sym_t sval_q;
    logic bfree_d, srdy_d;
    sym_t sval_d;

    always_comb begin
        bfree_d = bfree_q;
        if (core_bfree_set || reinit) bfree_d = 1'b1;
        if (cmd_wr && occupies_buffer(cmd_task)) bfree_d = 1'b0;

        srdy_d = srdy_q;
        if (stat_rd)      srdy_d = 1'b0;
        if (core_sym_stb) srdy_d = 1'b1;

        sval_d = sval_q;
        if (core_sym_stb && !mode_tx) sval_d = core_sym_val;
    end

    assign bfree_rise_o = went_high(bfree_d, bfree_q);
    assign empty_rise_o = went_high(core_in_empty, empty_q);
    assign ovf_rise_o   = went_high(core_ovf, ovf_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            bfree_q <= 1'b1;
            empty_q <= 1'b0;
            ovf_q   <= 1'b0;
            srdy_q  <= 1'b0;
            sval_q  <= '0;
        end else begin
            bfree_q <= bfree_d;
            empty_q <= core_in_empty;
            ovf_q   <= core_ovf;
            srdy_q  <= srdy_d;
            sval_q  <= sval_d;
        end
    end

    assign bfree_o    = bfree_q;
    assign in_empty_o = empty_q;
    assign ovf_o      = ovf_q;
    assign srdy_o     = srdy_q;
    assign sval_o     = sval_q;

    assert_task_clears_bfree_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && occupies_buffer(cmd_task)) |=> !bfree_q);
    assert_rx_symbol_capture_R7: assert property (@(posedge clk) disable iff (rst)
        (core_sym_stb && !mode_tx) |=> (srdy_q && sval_q == $past(core_sym_val)));
endmodule

// File: rtl/msi_irq_ctrl.sv
`timescale 1ns/1ps
module msi_irq_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic mask,
    input  logic bfree_rise,
    input  logic empty_rise,
    input  logic ovf_rise,
    input  logic sym_stb,
    input  logic sym_ien,
    input  logic pin_en,
    input  logic stat_rd,
    output logic irq_o,
    output logic pull_low_o
);
    logic irq_q;
    logic set_req;

    assign set_req = (!mask && (bfree_rise || empty_rise))
                   || ovf_rise
                   || (sym_ien && sym_stb);

    always_ff @(posedge clk) begin
        if (rst)          irq_q <= 1'b0;
        else if (set_req) irq_q <= 1'b1;
        else if (stat_rd) irq_q <= 1'b0;
    end

    assign irq_o      = irq_q;
    assign pull_low_o = pin_en & irq_q;

    assert_ovf_sets_irq_R3: assert property (@(posedge clk) disable iff (rst)
        ovf_rise |=> irq_q);
    assert_symbol_sets_irq_R7: assert property (@(posedge clk) disable iff (rst)
        (sym_stb && sym_ien) |=> irq_q);
    assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !ovf_rise && !sym_stb && !bfree_rise && !empty_rise) |=> !irq_q);
endmodule

// File: rtl/modem_stat_irq.sv
`timescale 1ns/1ps
module modem_stat_irq
    import msi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_tx,
    input  logic       mode_psave,
    input  logic       mode_sym_ien,
    input  logic       mode_pin_en,
    input  logic [1:0] mode_sym,
    input  logic       cmd_wr,
    input  logic [3:0] cmd_task,
    input  logic       core_bfree_set,
    input  logic       core_in_empty,
    input  logic       core_ovf,
    input  logic       core_sym_stb,
    input  logic [1:0] core_sym_val,
    input  logic       stat_rd,
    output logic [7:0] status_o,
    output logic       irq_o,
    output logic       irq_pull_low_o,
    output logic [1:0] tx_sym_o
);
    logic    reinit, mask;
    logic    bfree, in_empty, ovf, srdy;
    sym_t    sval;
    logic    bfree_rise, empty_rise, ovf_rise;
    logic    irq;
    status_t stat;

    msi_mask_gen u_mask (
        .clk(clk), .rst(rst), .mode_tx(mode_tx), .mode_psave(mode_psave),
        .cmd_wr(cmd_wr), .cmd_task(cmd_task), .reinit_o(reinit), .mask_o(mask)
    );

    msi_status_regs u_regs (
        .clk(clk), .rst(rst), .reinit(reinit), .cmd_wr(cmd_wr), .cmd_task(cmd_task),
        .core_bfree_set(core_bfree_set), .core_in_empty(core_in_empty),
        .core_ovf(core_ovf), .core_sym_stb(core_sym_stb), .core_sym_val(core_sym_val),
        .mode_tx(mode_tx), .stat_rd(stat_rd),
        .bfree_o(bfree), .in_empty_o(in_empty), .ovf_o(ovf), .srdy_o(srdy),
        .sval_o(sval), .bfree_rise_o(bfree_rise), .empty_rise_o(empty_rise),
        .ovf_rise_o(ovf_rise)
    );

    msi_irq_ctrl u_irq (
        .clk(clk), .rst(rst), .mask(mask), .bfree_rise(bfree_rise),
        .empty_rise(empty_rise), .ovf_rise(ovf_rise), .sym_stb(core_sym_stb),
        .sym_ien(mode_sym_ien), .pin_en(mode_pin_en), .stat_rd(stat_rd),
        .irq_o(irq), .pull_low_o(irq_pull_low_o)
    );

    always_comb begin
        stat.irq      = irq;
        stat.bfree    = bfree;
        stat.in_empty = in_empty;
        stat.ovf      = ovf;
        stat.srdy     = srdy;
        stat.spare    = 1'b0;
        stat.sval     = sval;
    end

    assign status_o = stat;
    assign irq_o    = irq;
    assign tx_sym_o = mode_tx ? mode_sym : '0;

    assert_pin_needs_flag_R9: assert property (@(posedge clk) disable iff (rst)
        irq_pull_low_o |-> (irq_o && mode_pin_en));
endmodule

// File: tb/modem_stat_irq_bench.sv
`timescale 1ns/1ps
module modem_stat_irq_bench;
    logic clk = 1'b0;
    logic rst;
    logic mode_tx, mode_psave, mode_sym_ien, mode_pin_en;
    logic [1:0] mode_sym;
    logic cmd_wr;
    logic [3:0] cmd_task;
    logic core_bfree_set, core_in_empty, core_ovf, core_sym_stb;
    logic [1:0] core_sym_val;
    logic stat_rd;
    logic [7:0] status_o;
    logic irq_o, irq_pull_low_o;
    logic [1:0] tx_sym_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // expected model state
    logic m_bfree, m_empty, m_ovf, m_srdy, m_irq, m_mask, m_ptx, m_pps;
    logic [1:0] m_sval;

    always #10 clk = ~clk;

    modem_stat_irq u_modem_stat_irq (
        .clk(clk), .rst(rst), .mode_tx(mode_tx), .mode_psave(mode_psave),
        .mode_sym_ien(mode_sym_ien), .mode_pin_en(mode_pin_en), .mode_sym(mode_sym),
        .cmd_wr(cmd_wr), .cmd_task(cmd_task), .core_bfree_set(core_bfree_set),
        .core_in_empty(core_in_empty), .core_ovf(core_ovf), .core_sym_stb(core_sym_stb),
        .core_sym_val(core_sym_val), .stat_rd(stat_rd), .status_o(status_o),
        .irq_o(irq_o), .irq_pull_low_o(irq_pull_low_o), .tx_sym_o(tx_sym_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status();
        return {m_irq, m_bfree, m_empty, m_ovf, m_srdy, 1'b0, m_sval};
    endfunction

    task automatic model_reset();
        m_bfree = 1; m_empty = 0; m_ovf = 0; m_srdy = 0; m_irq = 0;
        m_mask = 0; m_ptx = 0; m_pps = 0; m_sval = 0;
    endtask

    task automatic model_step();
        logic reinit, mwin, nb, setv;
        reinit = (cmd_wr && cmd_task == 4'd1) || (mode_tx != m_ptx) || (mode_psave != m_pps);
        mwin = reinit || m_mask;
        nb = m_bfree;
        if (core_bfree_set || reinit) nb = 1;
        if (cmd_wr && cmd_task > 4'd1) nb = 0;
        setv = (!mwin && ((nb && !m_bfree) || (core_in_empty && !m_empty)))
             || (core_ovf && !m_ovf) || (mode_sym_ien && core_sym_stb);
        if (setv) m_irq = 1; else if (stat_rd) m_irq = 0;
        if (core_sym_stb) m_srdy = 1; else if (stat_rd) m_srdy = 0;
        if (core_sym_stb && !mode_tx) m_sval = core_sym_val;
        m_bfree = nb; m_empty = core_in_empty; m_ovf = core_ovf;
        m_mask = reinit; m_ptx = mode_tx; m_pps = mode_psave;
    endtask

    // one cycle: inputs already set at a falling edge; model advances; compare one edge later
    task automatic cyc(input string tag);
        model_step();
        @(negedge clk);
        chk({tag, " R2 status"}, status_o, exp_status());
        chk("R9 pin", {7'd0, irq_pull_low_o}, {7'd0, mode_pin_en & m_irq});
        chk("R11 txsym", {6'd0, tx_sym_o}, {6'd0, mode_tx ? mode_sym : 2'b00});
        cmd_wr = 0; core_bfree_set = 0; core_sym_stb = 0; stat_rd = 0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1; mode_tx = 0; mode_psave = 0; mode_sym_ien = 0; mode_pin_en = 1;
        mode_sym = 0; cmd_wr = 0; cmd_task = 0; core_bfree_set = 0; core_in_empty = 0;
        core_ovf = 0; core_sym_stb = 0; core_sym_val = 0; stat_rd = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R1 reset status", status_o, 8'h40);
        chk("R1 reset pin", {7'd0, irq_pull_low_o}, 8'd0);

        core_ovf = 1; cyc("R3");
        chk("R3 ovf irq", {7'd0, status_o[7]}, 8'd1);
        stat_rd = 1; cyc("R8");
        chk("R8 read clears", {7'd0, irq_o}, 8'd0);

        cmd_wr = 1; cmd_task = 4'd2; core_bfree_set = 1; cyc("R10");
        chk("R10 task clears bfree", {7'd0, status_o[6]}, 8'd0);
        mode_tx = 1; core_bfree_set = 1; cyc("R6");
        chk("R6 masked bfree rise", {7'd0, irq_o}, 8'd0);
        core_in_empty = 1; cyc("R6");
        chk("R6 masked empty rise next cycle", {7'd0, irq_o}, 8'd0);
        core_in_empty = 0; cmd_wr = 1; cmd_task = 4'd3; cyc("R10");
        core_bfree_set = 1; cyc("R4");
        chk("R4 bfree rise irq", {7'd0, irq_o}, 8'd1);
        stat_rd = 1; cyc("R8");
        core_in_empty = 1; cyc("R5");
        chk("R5 empty rise irq", {7'd0, irq_o}, 8'd1);
        mode_sym_ien = 1; stat_rd = 1; core_sym_stb = 1; cyc("R8");
        chk("R8 set wins over read", {7'd0, irq_o}, 8'd1);
        mode_sym = 2'd3; cyc("R11");
        chk("R11 tx symbol", {6'd0, tx_sym_o}, 8'd3);
        stat_rd = 1; cyc("R8");
        mode_tx = 0; cyc("R6");
        chk("R6 mode change sets bfree", {7'd0, status_o[6]}, 8'd1);
        mode_sym = 2'd1; cyc("R11");
        chk("R11 rx ignores mode symbol", {6'd0, status_o[1:0]}, 8'd0);
        core_sym_stb = 1; core_sym_val = 2'd2; cyc("R7");
        chk("R7 rx symbol captured", {4'd0, status_o[3], 1'b0, status_o[1:0]}, 8'h0A);
        cmd_wr = 1; cmd_task = 4'd1; cyc("R6");
        chk("R6 reset task no irq change", {7'd0, status_o[6]}, 8'd1);

        for (int i = 0; i < 3000; i++) begin
            core_bfree_set = ($urandom % 8) == 0;
            if (($urandom % 6) == 0) core_in_empty = ~core_in_empty;
            if (($urandom % 9) == 0) core_ovf = ~core_ovf;
            core_sym_stb = ($urandom % 6) == 0;
            core_sym_val = 2'($urandom);
            stat_rd = ($urandom % 4) == 0;
            cmd_wr = ($urandom % 8) == 0;
            cmd_task = 4'($urandom % 4);
            if (($urandom % 40) == 0) mode_tx = ~mode_tx;
            if (($urandom % 60) == 0) mode_psave = ~mode_psave;
            if (($urandom % 20) == 0) mode_sym_ien = ~mode_sym_ien;
            if (($urandom % 20) == 0) mode_pin_en = ~mode_pin_en;
            mode_sym = 2'($urandom);
            cyc("R3 R4 R5 R6 R7 R8 R10");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule